// File: doc/BRIEF.md
# Tick-Divided Watchdog Timer

This block is a watchdog that protects a processor against runaway software. It counts pulses of a periodic real-time tick supplied by an upstream timer chain. After eight of those pulses without a service, it raises an internal reset request for exactly one clock cycle. The divider clears in that same cycle, so the watchdog starts a fresh period.

Software keeps the watchdog quiet by issuing a service write on a simple register bus, made of an address, write data and a write strobe. A service is a write to address 0x1FF0 whose data bit 0 is zero. A service clears only this block's own three-bit divider. The upstream tick source keeps running untouched, because it lies outside the block. Any other write leaves the watchdog as it was.

Top module: `tick_watchdog`

## Requirements
- R1: While `rst` is high the divider is held at 0 and `cop_rst_req` is 0. After `rst` is released, exactly eight tick pulses are needed before a request appears.
- R2: Each cycle with `rti_tick` high advances the divider by one. The request is registered: it appears in the cycle after the clock edge that captured the eighth tick.
- R3: `cop_rst_req` is high for exactly one clock cycle per timeout.
- R4: A timeout clears the divider. The next request needs eight more ticks.
- R5: A service write clears the divider, and eight further ticks are then needed for a request. A service write is `bus_we` high, `bus_addr` equal to 0x1FF0, and `bus_wdata` bit 0 equal to 0. The other data bits are don't-care.
- R6: A write to 0x1FF0 with `bus_wdata` bit 0 equal to 1 has no effect on the divider.
- R7: A write to any address other than 0x1FF0 has no effect on the divider.
- R8: Address and data presented with `bus_we` low have no effect on the divider.
- R9: When a service write and a tick occur in the same cycle, the service wins. The divider is left at 0 and no request is raised, even if the divider was at 7.
- R10: Cycles without a tick do not advance the divider, however many of them pass between ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| rti_tick | input | 1 | One-cycle periodic tick from the timer chain |
| bus_addr | input | 16 | Bus write address |
| bus_wdata | input | 8 | Bus write data |
| bus_we | input | 1 | Bus write strobe |
| cop_rst_req | output | 1 | One-cycle internal reset request |

## Verification
The bench counts the ticks needed for each request in several situations. It expects exactly eight ticks after reset, after a previous timeout, and after a service, and a design that miscounts would report the wrong number. It aims writes that nearly qualify at the divider: bit 0 set, a neighbouring address, and the strobe held low. A decoder that is too loose would clear the divider on these writes and make the next request late. A service that lands on the same cycle as the wrapping tick is the hardest case. If the tick wins there, the design fires at once or leaves the divider non-zero, and the request then comes early.

// File: rtl/tick_watchdog.sv
module tick_watchdog #(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 8,
  parameter logic [15:0] SVC_ADDR = 16'h1FF0,
  parameter int          SVC_BIT  = 0,
  parameter int          DIV_BITS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rti_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic              cop_rst_req
);
  localparam logic [DIV_BITS-1:0] LAST = {DIV_BITS{1'b1}};

  logic [DIV_BITS-1:0] div_q;
  logic                service;
  logic                wrap;
  logic                unused_wdata;

  assign service      = bus_we && (bus_addr == ADDR_W'(SVC_ADDR)) && !bus_wdata[SVC_BIT];
  assign wrap         = rti_tick && (div_q == LAST);
  assign unused_wdata = ^bus_wdata;

  always_ff @(posedge clk) begin
    if (rst || service) div_q <= '0;
    else if (rti_tick)  div_q <= div_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) cop_rst_req <= 1'b0;
    else     cop_rst_req <= wrap && !service;
  end
endmodule

// File: rtl/tick_watchdog_chk.sv
module tick_watchdog_chk #(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 8,
  parameter logic [15:0] SVC_ADDR = 16'h1FF0,
  parameter int          SVC_BIT  = 0,
  parameter int          DIV_BITS = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              rti_tick,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_we,
  input logic              cop_rst_req
);
  localparam int                  PERIOD = 1 << DIV_BITS;
  localparam logic [DIV_BITS:0]   FULL   = (DIV_BITS+1)'(PERIOD);

  logic [DIV_BITS:0] seen;
  logic              svc;

  assign svc = bus_we && (bus_addr == ADDR_W'(SVC_ADDR)) && (bus_wdata[SVC_BIT] == 1'b0);

  always_ff @(posedge clk) begin
    if (rst || svc)       seen <= '0;
    else if (cop_rst_req) seen <= rti_tick ? 1 : 0;
    else if (rti_tick && seen != FULL) seen <= seen + 1'b1;
  end

  a_r1_quiet_in_reset: assert property (@(posedge clk) rst |=> !cop_rst_req);
  a_r2_follows_tick:   assert property (@(posedge clk) disable iff (rst) cop_rst_req |-> $past(rti_tick));
  a_r3_single_cycle:   assert property (@(posedge clk) disable iff (rst) cop_rst_req |=> !cop_rst_req);
  a_r4_full_period:    assert property (@(posedge clk) disable iff (rst) cop_rst_req |-> seen == FULL);
  a_r9_service_wins:   assert property (@(posedge clk) disable iff (rst) svc |=> !cop_rst_req);
endmodule

bind tick_watchdog tick_watchdog_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SVC_ADDR(SVC_ADDR), .SVC_BIT(SVC_BIT), .DIV_BITS(DIV_BITS)
) u_chk (
  .clk(clk), .rst(rst), .rti_tick(rti_tick), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_we(bus_we), .cop_rst_req(cop_rst_req)
);

// File: tb/sim_tick_watchdog.sv
`timescale 1ns/1ps
module sim_tick_watchdog;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rti_tick = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        cop_rst_req;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tick_watchdog u0 (
    .clk(clk), .rst(rst), .rti_tick(rti_tick), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .cop_rst_req(cop_rst_req)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick_once(output bit fired);
    @(negedge clk);
    if (cop_rst_req) chk(0, "R3 request lasted more than one cycle", 1, 0);
    rti_tick = 1'b1;
    @(negedge clk);
    rti_tick = 1'b0;
    fired = cop_rst_req;
  endtask

  task automatic run_ticks(input int n, input int expect_at, input string tag);
    int first = 0;
    for (int i = 1; i <= n; i++) begin
      bit f;
      tick_once(f);
      if (f && first == 0) first = i;
    end
    chk(first == expect_at, tag, first, expect_at);
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input logic we, input logic tk,
                           output bit fired);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = we; rti_tick = tk;
    @(negedge clk);
    bus_we = 1'b0; rti_tick = 1'b0; bus_addr = '0; bus_wdata = '0;
    fired = cop_rst_req;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(cop_rst_req == 1'b0, "R1 request low during reset", cop_rst_req, 0);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    run_ticks(8, 8, "R1 R2 first request on eighth tick after reset");
  endtask

  task automatic t_period();
    run_ticks(8, 8, "R4 next request after eight more ticks");
    @(negedge clk);
    chk(cop_rst_req == 1'b0, "R3 request gone one cycle later", cop_rst_req, 0);
    run_ticks(8, 8, "R4 third period");
  endtask

  task automatic t_idle();
    do_reset();
    run_ticks(3, 0, "R10 no request after three ticks");
    repeat (20) @(negedge clk);
    chk(cop_rst_req == 1'b0, "R10 idle cycles raise nothing", cop_rst_req, 0);
    run_ticks(5, 5, "R10 idle gap does not advance divider");
  endtask

  task automatic t_service();
    bit f;
    do_reset();
    run_ticks(5, 0, "R5 pre-service ticks");
    bus_write(16'h1FF0, 8'h00, 1'b1, 1'b0, f);
    chk(f == 0, "R5 no request on service", f, 0);
    run_ticks(8, 8, "R5 eight ticks needed after service");
    run_ticks(6, 0, "R5 pre-service ticks upper bits");
    bus_write(16'h1FF0, 8'hFE, 1'b1, 1'b0, f);
    run_ticks(8, 8, "R5 service with other data bits set");
  endtask

  task automatic t_bit_set();
    bit f;
    do_reset();
    run_ticks(5, 0, "R6 pre-write ticks");
    bus_write(16'h1FF0, 8'h01, 1'b1, 1'b0, f);
    run_ticks(3, 3, "R6 bit0=1 write ignored");
  endtask

  task automatic t_other_addr();
    bit f;
    do_reset();
    run_ticks(5, 0, "R7 pre-write ticks");
    bus_write(16'h1FF1, 8'h00, 1'b1, 1'b0, f);
    bus_write(16'h0FF0, 8'h00, 1'b1, 1'b0, f);
    run_ticks(3, 3, "R7 other addresses ignored");
  endtask

  task automatic t_no_strobe();
    bit f;
    do_reset();
    run_ticks(5, 0, "R8 pre-write ticks");
    bus_write(16'h1FF0, 8'h00, 1'b0, 1'b0, f);
    run_ticks(3, 3, "R8 strobe low ignored");
  endtask

  task automatic t_collide();
    bit f;
    do_reset();
    run_ticks(7, 0, "R9 divider brought to seven");
    bus_write(16'h1FF0, 8'h00, 1'b1, 1'b1, f);
    chk(f == 0, "R9 no request when service meets wrapping tick", f, 0);
    run_ticks(8, 8, "R9 divider left at zero");
  endtask

  task automatic t_reset_mid();
    do_reset();
    run_ticks(6, 0, "R1 partial count before reset");
    do_reset();
    run_ticks(8, 8, "R1 reset mid-period clears divider");
  endtask

  initial begin
    t_reset();
    t_period();
    t_idle();
    t_service();
    t_bit_set();
    t_other_addr();
    t_no_strobe();
    t_collide();
    t_reset_mid();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule